// File: doc/BRIEF.md
# Capture/Compare Timer Channel with Event Flags

This block is one channel of a 16-bit timer. A free-running counter advances on a count-enable input. Four general registers, A to D, sit beside it. Each register works in one of two modes:

- In compare mode, the register raises its event flag when the counter passes its value.
- In capture mode, the register copies the counter when the matching capture pin rises, and raises its flag at the same time.

Software reaches the block through a small register bus. It clears a flag only by reading the flag as 1 and then writing 0 to it. A transfer engine can also clear a flag with an acknowledge, unless that engine's disable-select input is high. Each flag drives an interrupt request line, which has its own enable bit.

A parameter builds a reduced channel that has only registers A and B. In that channel the C and D slots are reserved.

Top module: `cct_top`

## Requirements
- R1: A compare event for a register happens in a cycle where `cnt_en` is 1, the register is in compare mode, and the counter equals the register. The flag is 1 after the next clock edge.
- R2: The capture pins pass through a two-flop synchronizer and then an edge detector. A rising edge on the pin of a capture-mode register copies the counter into that register and sets its flag. A capture pin of a compare-mode register changes neither that register nor its flag.
- R3: Writing a 1 to a status bit (address 1, bit 0 is A, up to bit 3 for D) leaves that flag as it was.
- R4: A status write of 0 clears a flag only if the most recent status read returned 1 for that bit. Each status read loads one arm bit per flag from the flag's current value. Any status write clears all arm bits. A 0 written without the arm bit set leaves the flag set.
- R5: A pulse on `xfer_ack[i]` clears flag i when `xfer_disel` is 0. When `xfer_disel` is 1, the flag stays set.
- R6: If a set event and a clear for the same flag fall in the same cycle, the flag ends at 1.
- R7: With `FULL_CHANNEL`=0, only registers A and B exist. The C and D status bits, interrupt lines and registers read as 0, and writes to them are ignored.
- R8: After reset the flags, the control register, the counter and all general registers are 0.
- R9: `irq[i]` is 1 exactly when flag i is 1 and the enable bit for i is 1. Control register layout at address 0:
  - bits [3:0] select capture mode for A..D (a bit of 1 means capture).
  - bits [7:4] are the interrupt enables for A..D.
- R10: The counter (address 2) increments by one on each clock where `cnt_en` is 1. A bus write to address 2 loads it. The general registers A..D are at addresses 4..7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_en | input | 1 | Counter advance enable |
| cap_in | input | 4 | Asynchronous capture pins, one for each of A..D |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 selects write, 0 selects read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the cycle of the access |
| xfer_ack | input | 4 | Transfer-engine acknowledge, one for each flag |
| xfer_disel | input | 1 | 1 keeps the flags set on acknowledge |
| irq | output | 4 | Interrupt requests for A..D |

## Verification
Two functions can meet in one clock: a flag being set, by a compare match or a capture, and a flag being cleared, by an armed write of 0 or by an acknowledge with disable-select low. The bench provokes this collision on purpose. It loads the counter with a register's value, arms the flag with a status read, and then raises `cnt_en` in the same cycle as the clearing write or the acknowledge. It judges the outcome by reading back the status register and expecting the flag still set. Random sequences of reads, writes, acknowledges and matches are checked against a bench model of flags and arm bits.

// File: rtl/cct_pkg.sv
// Package: register map and shared constants of the capture/compare timer.
// Assumes a 3-bit word address on the register bus.
package cct_pkg;
    localparam int ADDR_W  = 3;
    localparam int NSLOT   = 4;
    localparam int CTRL_W  = 2 * NSLOT;
    localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] A_STAT = 3'd1;
    localparam logic [ADDR_W-1:0] A_CNT  = 3'd2;
    // general registers occupy addresses 4..7: bit 2 set, low bits = slot
endpackage

// File: rtl/cct_counter.sv
// Module: free-running up counter with a synchronous load.
// Assumes the load has priority over counting in the same cycle.
module cct_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] count
);
    // count register: load wins, else advance on enable
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (load)
            count <= load_val;
        else if (en)
            count <= count + 1'b1;
    end
endmodule

// File: rtl/cct_edge_sync.sv
// Module: synchronizer chain followed by a rising-edge detector.
// Assumes STAGES >= 2. rise is a one-cycle pulse.
module cct_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    // shift the asynchronous input through the chain, remember last value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
            last_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], din};
            last_q  <= chain_q[STAGES-1];
        end
    end

    assign rise = chain_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/cct_flag_bank.sv
// Module: event flags with read-arm latches and two clear paths.
// Assumes rd_stb/wr_stb are status-register accesses of one cycle.
// Slots at or above NLIVE are reserved and tied to 0.
module cct_flag_bank #(
    parameter int NSLOT = 4,
    parameter int NLIVE = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSLOT-1:0] set_evt,
    input  logic             rd_stb,
    input  logic             wr_stb,
    input  logic [NSLOT-1:0] wr_bits,
    input  logic [NSLOT-1:0] ack,
    input  logic             disel,
    output logic [NSLOT-1:0] flags,
    output logic [NSLOT-1:0] arm
);
    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
        if (i < NLIVE) begin : g_live
            logic flag_q;
            logic arm_q;
            logic clr;

            assign clr = (wr_stb && !wr_bits[i] && arm_q) || (ack[i] && !disel);

            // flag: a set event beats any clear in the same cycle
            always_ff @(posedge clk) begin
                if (!rst_n)
                    flag_q <= 1'b0;
                else if (set_evt[i])
                    flag_q <= 1'b1;
                else if (clr)
                    flag_q <= 1'b0;
            end

            // arm latch: loaded by a status read, consumed by a status write
            always_ff @(posedge clk) begin
                if (!rst_n)
                    arm_q <= 1'b0;
                else if (wr_stb)
                    arm_q <= 1'b0;
                else if (rd_stb)
                    arm_q <= flag_q;
            end

            assign flags[i] = flag_q;
            assign arm[i]   = arm_q;
        end else begin : g_rsvd
            logic unused_bits;
            assign unused_bits = ^{set_evt[i], wr_bits[i], ack[i]};
            assign flags[i]    = 1'b0;
            assign arm[i]      = 1'b0;
        end
    end
endmodule

// File: rtl/cct_top.sv
// Module: one timer channel. It has a counter, general registers A..D
// (capture or compare), event flags, interrupt lines and register access.
// Assumes bus_rdata is read combinationally in the access cycle, and W >= 8.
module cct_top
    import cct_pkg::*;
#(
    parameter int W            = 16,
    parameter bit FULL_CHANNEL = 1'b1,
    parameter int SYNC_STAGES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_en,
    input  logic [NSLOT-1:0]  cap_in,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    input  logic [NSLOT-1:0]  xfer_ack,
    input  logic              xfer_disel,
    output logic [NSLOT-1:0]  irq
);
    localparam int NREG = FULL_CHANNEL ? NSLOT : 2;

    logic              acc_rd, acc_wr, stat_rd, stat_wr, cnt_ld;
    logic [CTRL_W-1:0] ctrl_q;
    logic [NSLOT-1:0]  mode_cap, irq_en;
    logic [W-1:0]      count;
    logic [NSLOT-1:0]  cap_rise, set_evt, flag_vec, arm_vec;
    logic [W-1:0]      gr_vec [NSLOT];

    assign acc_rd   = bus_sel && !bus_wr;
    assign acc_wr   = bus_sel && bus_wr;
    assign stat_rd  = acc_rd && (bus_addr == A_STAT);
    assign stat_wr  = acc_wr && (bus_addr == A_STAT);
    assign cnt_ld   = acc_wr && (bus_addr == A_CNT);
    assign mode_cap = ctrl_q[NSLOT-1:0];
    assign irq_en   = ctrl_q[CTRL_W-1:NSLOT];

    // control register: mode select and interrupt enables
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (acc_wr && (bus_addr == A_CTRL))
            ctrl_q <= bus_wdata[CTRL_W-1:0];
    end

    cct_counter #(.W(W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (cnt_en),
        .load     (cnt_ld),
        .load_val (bus_wdata),
        .count    (count)
    );

    for (genvar i = 0; i < NSLOT; i++) begin : g_reg
        if (i < NREG) begin : g_live
            logic [W-1:0] gr_q;
            logic         gr_wr;

            cct_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk   (clk),
                .rst_n (rst_n),
                .din   (cap_in[i]),
                .rise  (cap_rise[i])
            );

            assign gr_wr = acc_wr && bus_addr[2] && (bus_addr[1:0] == 2'(i));

            // general register: capture has priority over a bus write
            always_ff @(posedge clk) begin
                if (!rst_n)
                    gr_q <= '0;
                else if (mode_cap[i] && cap_rise[i])
                    gr_q <= count;
                else if (gr_wr)
                    gr_q <= bus_wdata;
            end

            assign gr_vec[i]  = gr_q;
            assign set_evt[i] = mode_cap[i] ? cap_rise[i]
                                            : (cnt_en && (count == gr_q));
        end else begin : g_rsvd
            logic unused_pin;
            assign unused_pin  = cap_in[i];
            assign cap_rise[i] = 1'b0;
            assign gr_vec[i]   = '0;
            assign set_evt[i]  = 1'b0;
        end
    end

    cct_flag_bank #(.NSLOT(NSLOT), .NLIVE(NREG)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_evt (set_evt),
        .rd_stb  (stat_rd),
        .wr_stb  (stat_wr),
        .wr_bits (bus_wdata[NSLOT-1:0]),
        .ack     (xfer_ack),
        .disel   (xfer_disel),
        .flags   (flag_vec),
        .arm     (arm_vec)
    );

    assign irq = flag_vec & irq_en;

    // read multiplexer over the register map
    always_comb begin
        bus_rdata = '0;
        if (bus_addr[2])
            bus_rdata = gr_vec[bus_addr[1:0]];
        else if (bus_addr == A_CTRL)
            bus_rdata = {{(W-CTRL_W){1'b0}}, ctrl_q};
        else if (bus_addr == A_STAT)
            bus_rdata = {{(W-NSLOT){1'b0}}, flag_vec};
        else if (bus_addr == A_CNT)
            bus_rdata = count;
    end
endmodule

// File: rtl/cct_top_chk.sv
// Module: assertion checker for cct_top, attached with bind.
// Assumes the signals are sampled at the rising clock edge.
module cct_top_chk #(
    parameter int NSLOT = 4,
    parameter int NLIVE = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NSLOT-1:0] flags,
    input logic [NSLOT-1:0] arm,
    input logic [NSLOT-1:0] set_evt,
    input logic             stat_wr,
    input logic [NSLOT-1:0] wr_bits,
    input logic [NSLOT-1:0] ack,
    input logic             disel,
    input logic [NSLOT-1:0] irq,
    input logic [NSLOT-1:0] ie
);
    for (genvar i = 0; i < NSLOT; i++) begin : g_chk
        if (i < NLIVE) begin : g_live
            AST_EVENT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
                set_evt[i] |=> flags[i]); // R1
            AST_WRITE_ONE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
                (flags[i] && stat_wr && wr_bits[i] && !(ack[i] && !disel)) |=> flags[i]); // R3
            AST_UNARMED_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
                (flags[i] && stat_wr && !arm[i] && !(ack[i] && !disel)) |=> flags[i]); // R4
            AST_CLEAR_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(flags[i]) |-> $past(stat_wr || ack[i])); // R4
            AST_DISEL_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
                (flags[i] && ack[i] && disel && !stat_wr) |=> flags[i]); // R5
            AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
                (set_evt[i] && ((stat_wr && !wr_bits[i] && arm[i]) || (ack[i] && !disel)))
                |=> flags[i]); // R6
            AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
                irq[i] |-> (ie[i] && flags[i])); // R9
        end else begin : g_rsvd
            AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
                !flags[i] && !irq[i]); // R7
        end
    end
endmodule

bind cct_top cct_top_chk #(.NSLOT(cct_pkg::NSLOT), .NLIVE(NREG)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .flags   (flag_vec),
    .arm     (arm_vec),
    .set_evt (set_evt),
    .stat_wr (stat_wr),
    .wr_bits (bus_wdata[3:0]),
    .ack     (xfer_ack),
    .disel   (xfer_disel),
    .irq     (irq),
    .ie      (ctrl_q[7:4])
);

// File: tb/cct_top_tb_top.sv
// Bench: a full channel and a reduced channel share one stimulus.
// Directed corner cases, then seeded random status traffic against a model.
module cct_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_en = 1'b0;
    logic [3:0]  cap_in = '0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [3:0]  xfer_ack = '0;
    logic        xfer_disel = 1'b0;
    logic [15:0] rdata_f, rdata_r;
    logic [3:0]  irq_f, irq_r;

    int checks = 0, fails = 0;
    bit done = 1'b0;
    logic [15:0] rd_f, rd_r;
    logic [15:0] exp_gr [4];
    logic [3:0]  exp_flag, exp_arm;

    always #4 clk = ~clk;

    cct_top #(.FULL_CHANNEL(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .cap_in(cap_in),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata_f),
        .xfer_ack(xfer_ack), .xfer_disel(xfer_disel), .irq(irq_f));

    cct_top #(.FULL_CHANNEL(1'b0)) red_i (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .cap_in(cap_in),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata_r),
        .xfer_ack(xfer_ack), .xfer_disel(xfer_disel), .irq(irq_r));

    function automatic logic [3:0] f_after_write(input logic [3:0] fl, input logic [3:0] ar,
                                                 input logic [3:0] w);
        return fl & ~(ar & ~w);
    endfunction

    function automatic logic [3:0] f_after_ack(input logic [3:0] fl, input logic [3:0] a,
                                               input logic d);
        return d ? fl : (fl & ~a);
    endfunction

    function automatic logic [3:0] f_hits(input logic [15:0] v);
        logic [3:0] h;
        for (int i = 0; i < 4; i++) h[i] = (exp_gr[i] == v);
        return h;
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        rd_f = rdata_f; rd_r = rdata_r;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic set_gr(input int i, input logic [15:0] v);
        bus_write(3'(4 + i), v);
        exp_gr[i] = v;
    endtask

    // load counter with v and let it count once: a match on every register equal to v
    task automatic do_cmp(input logic [15:0] v);
        bus_write(3'd2, v);
        @(negedge clk); cnt_en = 1'b1;
        @(negedge clk); cnt_en = 1'b0;
    endtask

    task automatic clear_all;
        bus_read(3'd1);
        bus_write(3'd1, 16'h0000);
    endtask

    task automatic pulse_ack(input logic [3:0] a, input logic d);
        @(negedge clk); xfer_ack = a; xfer_disel = d;
        @(negedge clk); xfer_ack = '0; xfer_disel = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 4; i++) exp_gr[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R8: reset state
        bus_read(3'd1); check("R8 status", rd_f, 16'h0); check("R8 reduced status", rd_r, 16'h0);
        bus_read(3'd0); check("R8 ctrl", rd_f, 16'h0);
        bus_read(3'd2); check("R8 counter", rd_f, 16'h0);
        bus_read(3'd6); check("R8 gr C", rd_f, 16'h0);
        check("R8 irq", {12'h0, irq_f}, 16'h0);

        // R10: load and count three enabled cycles
        bus_write(3'd2, 16'h0100);
        @(negedge clk); cnt_en = 1'b1;
        repeat (3) @(negedge clk);
        cnt_en = 1'b0;
        bus_read(3'd2); check("R10 counter +3", rd_f, 16'h0103);
        bus_read(3'd1); check("R10 no stray flag", rd_f, 16'h0);

        // R1: match on the third enabled count
        set_gr(0, 16'h0200);
        bus_write(3'd2, 16'h01FE);
        @(negedge clk); cnt_en = 1'b1;
        repeat (3) @(negedge clk);
        cnt_en = 1'b0;
        bus_read(3'd1); check("R1 compare flag A", rd_f, 16'h0001);

        // R3: write 1 after an arming read keeps the flag
        bus_write(3'd1, 16'h0001);
        bus_read(3'd1); check("R3 write one keeps", rd_f, 16'h0001);

        // R4: armed write 0 clears
        bus_write(3'd1, 16'h000E);
        bus_read(3'd1); check("R4 armed clear", rd_f, 16'h0000);

        // R4: flag set after the read (not armed), write 0 leaves it
        do_cmp(16'h0200);
        bus_write(3'd1, 16'h0000);
        bus_read(3'd1); check("R4 unarmed keeps", rd_f, 16'h0001);
        bus_write(3'd1, 16'h0000);
        bus_read(3'd1); check("R4 rearmed clear", rd_f, 16'h0000);

        // R5: acknowledge with and without disable-select
        do_cmp(16'h0200);
        pulse_ack(4'b0001, 1'b1);
        bus_read(3'd1); check("R5 disel keeps", rd_f, 16'h0001);
        pulse_ack(4'b0001, 1'b0);
        bus_read(3'd1); check("R5 ack clears", rd_f, 16'h0000);

        // R6: armed clearing write in the same cycle as a match
        do_cmp(16'h0200);
        bus_write(3'd2, 16'h0200);
        bus_read(3'd1);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 3'd1; bus_wdata = 16'h0000; cnt_en = 1'b1;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; cnt_en = 1'b0;
        bus_read(3'd1); check("R6 set beats write clear", rd_f, 16'h0001);
        // R6: acknowledge in the same cycle as a match
        bus_write(3'd2, 16'h0200);
        @(negedge clk); xfer_ack = 4'b0001; xfer_disel = 1'b0; cnt_en = 1'b1;
        @(negedge clk); xfer_ack = '0; cnt_en = 1'b0;
        bus_read(3'd1); check("R6 set beats ack", rd_f, 16'h0001);
        clear_all();

        // R9: interrupt lines follow flag and enable
        set_gr(1, 16'h0300);
        bus_write(3'd0, 16'h0010);
        do_cmp(16'h0200);
        do_cmp(16'h0300);
        @(negedge clk); #1;
        check("R9 irq A only", {12'h0, irq_f}, 16'h0001);
        bus_write(3'd0, 16'h0030);
        @(negedge clk); #1;
        check("R9 irq A and B", {12'h0, irq_f}, 16'h0003);
        clear_all();

        // R2: capture on A, B in compare mode ignores its pin
        set_gr(1, 16'h0055);
        bus_write(3'd0, 16'h0001);
        bus_write(3'd2, 16'h4321);
        @(negedge clk); cap_in = 4'b0011;
        repeat (4) @(negedge clk);
        cap_in = 4'b0000;
        repeat (4) @(negedge clk);
        bus_read(3'd4); check("R2 captured value A", rd_f, 16'h4321);
        bus_read(3'd5); check("R2 compare-mode B unchanged", rd_f, 16'h0055);
        bus_read(3'd1); check("R2 capture flag A only", rd_f, 16'h0001);
        exp_gr[0] = 16'h4321;
        clear_all();

        // random status traffic, all compare mode, all interrupts enabled
        bus_write(3'd0, 16'h00F0);
        for (int i = 0; i < 4; i++) set_gr(i, 16'($urandom));
        exp_flag = '0; exp_arm = '0;
        for (int n = 0; n < 300; n++) begin
            int op;
            op = int'($urandom % 4);
            case (op)
                0: begin
                    bus_read(3'd1);
                    check("R3/R4/R5 random status", rd_f, {12'h0, exp_flag});
                    exp_arm = exp_flag;
                end
                1: begin
                    logic [3:0] w;
                    w = 4'($urandom);
                    bus_write(3'd1, {12'h0, w});
                    exp_flag = f_after_write(exp_flag, exp_arm, w);
                    exp_arm = '0;
                end
                2: begin
                    logic [3:0] a;
                    logic d;
                    a = 4'($urandom); d = 1'($urandom);
                    pulse_ack(a, d);
                    exp_flag = f_after_ack(exp_flag, a, d);
                end
                default: begin
                    logic [15:0] v;
                    v = exp_gr[$urandom % 4];
                    do_cmp(v);
                    exp_flag = exp_flag | f_hits(v);
                end
            endcase
            @(negedge clk); #1;
            check("R9 random irq", {12'h0, irq_f}, {12'h0, exp_flag});
        end

        // R7: reduced channel hides C and D
        for (int i = 0; i < 4; i++) set_gr(i, 16'h0077);
        do_cmp(16'h0077);
        bus_read(3'd1);
        check("R7 full status", rd_f, 16'h000F);
        check("R7 reduced status", rd_r, 16'h0003);
        bus_read(3'd6); check("R7 reduced gr C", rd_r, 16'h0000);
        bus_read(3'd7); check("R7 reduced gr D", rd_r, 16'h0000);
        check("R7 reduced irq", {12'h0, irq_r}, 16'h0003);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule